// File: doc/BRIEF.md
# Phase-Tracking Transaction Barrier Unit

This block keeps a small array of synchronisation objects. Each object tracks its validity, a one-bit phase and three 20-bit counters: the expected arrivals per phase, the arrivals still pending in the current phase, and the asynchronous transactions still outstanding. Requesters send commands on a single command port, and each command names an object index. The block answers every command one cycle later with an error flag and a token. When a command closes a phase, it also raises a one-cycle completion pulse for that object.

A phase closes only when the pending arrivals and the outstanding transactions are both zero. At that point the phase bit flips and the pending count is reloaded from the expected count. A separate query port tests whether a phase has finished and answers combinationally from the registered object state. The phase can be given directly as a parity bit, or taken from a token that an earlier command returned.

Top module: `barrier_unit`

## Requirements
- R1: Opcode 0 (setup) on an invalid object with a nonzero argument makes the object valid. It sets the phase to 0, loads the argument into both the expected and pending counts, and clears the transaction count. A setup never produces a completion pulse.
- R2: A setup with argument 0, or a setup on an object that is already valid, is rejected with `rsp_err`=1 and leaves the object unchanged. The largest accepted argument is 2^20-1.
- R3: Every command accepted on the port yields `rsp_valid`=1 exactly one cycle later. `rsp_token` then holds the object index in bits [IDX_W:1] and the object's phase from before the command in bit 0. A cycle with no command yields `rsp_valid`=0.
- R4: Opcode 3 (partial arrive) subtracts its argument from the pending count and never completes a phase. If the argument is greater than or equal to the pending count, the command is rejected with an error and the state is unchanged.
- R5: Opcode 4 (expect then arrive) adds its argument to the transaction count and then arrives once. It is rejected with no state change if the pending count is already 0 or if the transaction count would exceed 2^20-1.
- R6: When an accepted arrive-type or transaction command leaves both the pending count and the transaction count at 0, the phase toggles and the pending count is reloaded from the expected count. `done_pulse` then has exactly that object's bit set for one cycle. At most one bit of `done_pulse` is ever set.
- R7: Opcode 5 (transactions done) subtracts its argument from the transaction count. If the argument is larger than the count, the count saturates at 0 and `rsp_err`=1, and the completion rule still applies.
- R8: With `qry_mode`=0, `qry_done` is 1 when the object at `qry_idx` is valid and its current phase differs from `qry_parity`. The answer is combinational.
- R9: With `qry_mode`=1, the object index and phase are taken from `qry_token` in the layout of R3, and `qry_idx` is ignored. `qry_done` is 1 when that object is valid and its current phase differs from the token's phase bit.
- R10: Opcode 1 (invalidate) clears the object's valid bit. Invalidating an invalid object is an error. Any opcode other than setup on an invalid object is rejected with no state change, and queries on an invalid object return 0.
- R11: Opcode 2 (arrive) decrements the pending count by 1 and is rejected if the pending count is 0. Opcodes 6 and 7, and an index of NUM_OBJ or above, are rejected with an error and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; all objects invalid |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 3 | Opcode: 0 setup, 1 invalidate, 2 arrive, 3 partial arrive, 4 expect then arrive, 5 transactions done |
| cmd_idx | input | IDX_W | Object index |
| cmd_arg | input | 20 | Count argument |
| rsp_valid | output | 1 | Response present (one cycle after the command) |
| rsp_err | output | 1 | Command rejected or transaction underflow |
| rsp_token | output | IDX_W+1 | {index, phase before the command} |
| done_pulse | output | NUM_OBJ | One-cycle phase-completion pulse per object |
| qry_mode | input | 1 | 0 parity test, 1 token test |
| qry_idx | input | IDX_W | Object index for a parity test |
| qry_parity | input | 1 | Parity of the phase being tested |
| qry_token | input | IDX_W+1 | Token for a token test |
| qry_done | output | 1 | Tested phase has completed |

## Verification
A command sampled at one rising edge has its `rsp_valid`, `rsp_err`, `rsp_token` and `done_pulse` due just after that edge, one cycle later, and the object's new state takes effect at the same edge. The bench drives each command at a falling edge and removes it at the next falling edge, then reads all four response signals at that point. It also applies a query and reads `qry_done` after a short settle delay, because the query has no register of its own and reflects the state written at the preceding rising edge. Each rejection is confirmed through a later command or query whose outcome would differ if the state had changed.

// File: rtl/barrier_pkg.sv
package barrier_pkg;

    parameter int CNT_W = 20;

    typedef enum logic [2:0] {
        OP_SETUP    = 3'd0,
        OP_INVAL    = 3'd1,
        OP_ARRIVE   = 3'd2,
        OP_PARTIAL  = 3'd3,
        OP_EXPECT   = 3'd4,
        OP_TX_DONE  = 3'd5
    } bar_op_e;

    typedef struct packed {
        logic             valid;
        logic             phase;
        logic [CNT_W-1:0] expected;
        logic [CNT_W-1:0] pending;
        logic [CNT_W-1:0] tx;
    } bar_obj_t;

endpackage

// File: rtl/barrier_cmd_eval.sv
module barrier_cmd_eval
    import barrier_pkg::*;
(
    input  bar_obj_t         obj_i,
    input  logic [2:0]       op_i,
    input  logic [CNT_W-1:0] arg_i,
    output bar_obj_t         obj_o,
    output logic             err_o,
    output logic             cpl_o
);

    logic [CNT_W:0] tx_sum;
    logic           try_close;
    bar_obj_t       nxt;

    assign tx_sum = {1'b0, obj_i.tx} + {1'b0, arg_i};

    always_comb begin
        nxt       = obj_i;
        err_o     = 1'b0;
        try_close = 1'b0;
        case (op_i)
            OP_SETUP: begin
                if (obj_i.valid || (arg_i == '0)) begin
                    err_o = 1'b1;
                end else begin
                    nxt.valid    = 1'b1;
                    nxt.phase    = 1'b0;
                    nxt.expected = arg_i;
                    nxt.pending  = arg_i;
                    nxt.tx       = '0;
                end
            end
            OP_INVAL: begin
                if (!obj_i.valid) err_o = 1'b1;
                else              nxt.valid = 1'b0;
            end
            OP_ARRIVE: begin
                if (!obj_i.valid || (obj_i.pending == '0)) begin
                    err_o = 1'b1;
                end else begin
                    nxt.pending = obj_i.pending - 1'b1;
                    try_close   = 1'b1;
                end
            end
            OP_PARTIAL: begin
                if (!obj_i.valid || (arg_i >= obj_i.pending)) begin
                    err_o = 1'b1;
                end else begin
                    nxt.pending = obj_i.pending - arg_i;
                end
            end
            OP_EXPECT: begin
                if (!obj_i.valid || (obj_i.pending == '0) || tx_sum[CNT_W]) begin
                    err_o = 1'b1;
                end else begin
                    nxt.tx      = tx_sum[CNT_W-1:0];
                    nxt.pending = obj_i.pending - 1'b1;
                    try_close   = 1'b1;
                end
            end
            OP_TX_DONE: begin
                if (!obj_i.valid) begin
                    err_o = 1'b1;
                end else if (arg_i > obj_i.tx) begin
                    err_o     = 1'b1;
                    nxt.tx    = '0;
                    try_close = 1'b1;
                end else begin
                    nxt.tx    = obj_i.tx - arg_i;
                    try_close = 1'b1;
                end
            end
            default: err_o = 1'b1;
        endcase

        cpl_o = 1'b0;
        if (try_close && (nxt.pending == '0) && (nxt.tx == '0)) begin
            nxt.phase   = ~obj_i.phase;
            nxt.pending = obj_i.expected;
            cpl_o       = 1'b1;
        end
        obj_o = nxt;
    end

endmodule

// File: rtl/barrier_query.sv
module barrier_query #(
    parameter int NUM_OBJ = 4,
    parameter int IDX_W   = 2
) (
    input  logic [NUM_OBJ-1:0] valid_vec,
    input  logic [NUM_OBJ-1:0] phase_vec,
    input  logic               mode_i,
    input  logic [IDX_W-1:0]   idx_i,
    input  logic               parity_i,
    input  logic [IDX_W:0]     token_i,
    output logic               done_o
);

    logic [IDX_W-1:0] sel;
    logic             ref_phase;

    always_comb begin
        if (mode_i) begin
            sel       = token_i[IDX_W:1];
            ref_phase = token_i[0];
        end else begin
            sel       = idx_i;
            ref_phase = parity_i;
        end
        done_o = 1'b0;
        for (int i = 0; i < NUM_OBJ; i++) begin
            if (int'(sel) == i) begin
                done_o = valid_vec[i] && (phase_vec[i] != ref_phase);
            end
        end
    end

endmodule

// File: rtl/barrier_unit.sv
module barrier_unit
    import barrier_pkg::*;
#(
    parameter  int NUM_OBJ = 4,
    localparam int IDX_W   = (NUM_OBJ > 1) ? $clog2(NUM_OBJ) : 1,
    localparam int TOK_W   = IDX_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [2:0]         cmd_op,
    input  logic [IDX_W-1:0]   cmd_idx,
    input  logic [CNT_W-1:0]   cmd_arg,
    output logic               rsp_valid,
    output logic               rsp_err,
    output logic [TOK_W-1:0]   rsp_token,
    output logic [NUM_OBJ-1:0] done_pulse,
    input  logic               qry_mode,
    input  logic [IDX_W-1:0]   qry_idx,
    input  logic               qry_parity,
    input  logic [TOK_W-1:0]   qry_token,
    output logic               qry_done
);

    typedef struct packed {
        bar_obj_t [NUM_OBJ-1:0] obj;
        logic                   rsp_valid;
        logic                   rsp_err;
        logic [TOK_W-1:0]       rsp_token;
        logic [NUM_OBJ-1:0]     done;
    } unit_st_t;

    unit_st_t           st_d, st_q;
    bar_obj_t           sel_obj, upd_obj;
    logic               idx_ok, eval_err, eval_cpl;
    logic [NUM_OBJ-1:0] valid_vec, phase_vec;

    always_comb begin
        idx_ok  = 1'b0;
        sel_obj = '0;
        for (int i = 0; i < NUM_OBJ; i++) begin
            if (int'(cmd_idx) == i) begin
                idx_ok  = 1'b1;
                sel_obj = st_q.obj[i];
            end
        end
    end

    barrier_cmd_eval u_eval (
        .obj_i (sel_obj),
        .op_i  (cmd_op),
        .arg_i (cmd_arg),
        .obj_o (upd_obj),
        .err_o (eval_err),
        .cpl_o (eval_cpl)
    );

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = cmd_valid;
        st_d.rsp_err   = 1'b0;
        st_d.done      = '0;
        if (cmd_valid) begin
            st_d.rsp_token = {cmd_idx, sel_obj.phase};
            if (!idx_ok) begin
                st_d.rsp_err = 1'b1;
            end else begin
                st_d.rsp_err = eval_err;
                for (int i = 0; i < NUM_OBJ; i++) begin
                    if (int'(cmd_idx) == i) begin
                        st_d.obj[i]  = upd_obj;
                        st_d.done[i] = eval_cpl;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NUM_OBJ; g++) begin : g_vec
        assign valid_vec[g] = st_q.obj[g].valid;
        assign phase_vec[g] = st_q.obj[g].phase;
    end

    barrier_query #(
        .NUM_OBJ (NUM_OBJ),
        .IDX_W   (IDX_W)
    ) u_query (
        .valid_vec (valid_vec),
        .phase_vec (phase_vec),
        .mode_i    (qry_mode),
        .idx_i     (qry_idx),
        .parity_i  (qry_parity),
        .token_i   (qry_token),
        .done_o    (qry_done)
    );

    assign rsp_valid  = st_q.rsp_valid;
    assign rsp_err    = st_q.rsp_err;
    assign rsp_token  = st_q.rsp_token;
    assign done_pulse = st_q.done;

endmodule

// File: rtl/barrier_unit_chk.sv
module barrier_unit_chk #(
    parameter  int NUM_OBJ = 4,
    localparam int IDX_W   = (NUM_OBJ > 1) ? $clog2(NUM_OBJ) : 1,
    localparam int TOK_W   = IDX_W + 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_valid,
    input logic [2:0]         cmd_op,
    input logic [IDX_W-1:0]   cmd_idx,
    input logic [19:0]        cmd_arg,
    input logic               rsp_valid,
    input logic               rsp_err,
    input logic [TOK_W-1:0]   rsp_token,
    input logic [NUM_OBJ-1:0] done_pulse
);

    AST_RSP_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> rsp_valid);                                           // R3
    AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !rsp_valid);                                         // R3
    AST_TOKEN_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> (rsp_token[TOK_W-1:1] == $past(cmd_idx)));            // R3
    AST_SETUP_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd0) |=> (done_pulse == '0));              // R1
    AST_ZERO_SETUP_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd0 && cmd_arg == '0) |=> rsp_err);        // R2
    AST_PARTIAL_NEVER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd3) |=> (done_pulse == '0));              // R4
    AST_DONE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done_pulse));                                              // R6
    AST_DONE_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (|done_pulse) |-> (rsp_valid && done_pulse[rsp_token[TOK_W-1:1]])); // R6
    AST_BAD_OP_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op > 3'd5) |=> (rsp_err && done_pulse == '0));    // R11

endmodule

bind barrier_unit barrier_unit_chk #(.NUM_OBJ(NUM_OBJ)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_idx    (cmd_idx),
    .cmd_arg    (cmd_arg),
    .rsp_valid  (rsp_valid),
    .rsp_err    (rsp_err),
    .rsp_token  (rsp_token),
    .done_pulse (done_pulse)
);

// File: tb/barrier_unit_tb_top.sv
module barrier_unit_tb_top;

    localparam int NOBJ = 4;
    localparam int NV   = 20;

    typedef struct packed {
        logic [2:0]  op;
        logic [1:0]  idx;
        logic [19:0] arg;
        logic        err;
        logic [2:0]  tok;
        logic        dn;
        logic        qd;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{3'd0, 2'd0, 20'd2,   1'b0, 3'b000, 1'b0, 1'b0},
        '{3'd2, 2'd0, 20'd0,   1'b0, 3'b000, 1'b0, 1'b0},
        '{3'd2, 2'd0, 20'd0,   1'b0, 3'b000, 1'b1, 1'b1},
        '{3'd3, 2'd0, 20'd1,   1'b0, 3'b001, 1'b0, 1'b1},
        '{3'd3, 2'd0, 20'd1,   1'b1, 3'b001, 1'b0, 1'b1},
        '{3'd4, 2'd0, 20'd100, 1'b0, 3'b001, 1'b0, 1'b1},
        '{3'd2, 2'd0, 20'd0,   1'b1, 3'b001, 1'b0, 1'b1},
        '{3'd5, 2'd0, 20'd40,  1'b0, 3'b001, 1'b0, 1'b1},
        '{3'd5, 2'd0, 20'd60,  1'b0, 3'b001, 1'b1, 1'b0},
        '{3'd0, 2'd1, 20'd0,   1'b1, 3'b010, 1'b0, 1'b0},
        '{3'd0, 2'd1, 20'd1,   1'b0, 3'b010, 1'b0, 1'b0},
        '{3'd5, 2'd1, 20'd5,   1'b1, 3'b010, 1'b0, 1'b0},
        '{3'd4, 2'd1, 20'd0,   1'b0, 3'b010, 1'b1, 1'b1},
        '{3'd0, 2'd1, 20'd3,   1'b1, 3'b011, 1'b0, 1'b1},
        '{3'd1, 2'd1, 20'd0,   1'b0, 3'b011, 1'b0, 1'b0},
        '{3'd1, 2'd1, 20'd0,   1'b1, 3'b011, 1'b0, 1'b0},
        '{3'd2, 2'd1, 20'd0,   1'b1, 3'b011, 1'b0, 1'b0},
        '{3'd7, 2'd0, 20'd0,   1'b1, 3'b000, 1'b0, 1'b0},
        '{3'd0, 2'd1, 20'd1,   1'b0, 3'b011, 1'b0, 1'b0},
        '{3'd2, 2'd1, 20'd0,   1'b0, 3'b010, 1'b1, 1'b1}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cmd_valid = 1'b0;
    logic [2:0]      cmd_op = '0;
    logic [1:0]      cmd_idx = '0;
    logic [19:0]     cmd_arg = '0;
    logic            rsp_valid, rsp_err, qry_done;
    logic [2:0]      rsp_token;
    logic [NOBJ-1:0] done_pulse;
    logic            qry_mode = 1'b0;
    logic [1:0]      qry_idx = '0;
    logic            qry_parity = 1'b0;
    logic [2:0]      qry_token = '0;

    int  n_cmp  = 0;
    int  n_bad  = 0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    barrier_unit #(.NUM_OBJ(NOBJ)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_idx    (cmd_idx),
        .cmd_arg    (cmd_arg),
        .rsp_valid  (rsp_valid),
        .rsp_err    (rsp_err),
        .rsp_token  (rsp_token),
        .done_pulse (done_pulse),
        .qry_mode   (qry_mode),
        .qry_idx    (qry_idx),
        .qry_parity (qry_parity),
        .qry_token  (qry_token),
        .qry_done   (qry_done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [1:0] idx, input logic [19:0] arg);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_idx   = idx;
        cmd_arg   = arg;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic parity_q(input logic [1:0] idx, input logic par);
        qry_mode   = 1'b0;
        qry_idx    = idx;
        qry_parity = par;
        #1;
    endtask

    task automatic token_q(input logic [2:0] tok, input logic [1:0] decoy);
        qry_mode  = 1'b1;
        qry_token = tok;
        qry_idx   = decoy;
        #1;
    endtask

    function automatic string req_of(input logic [2:0] op);
        case (op)
            3'd0:    return "R1 setup";
            3'd1:    return "R10 invalidate";
            3'd2:    return "R11 arrive";
            3'd3:    return "R4 partial arrive";
            3'd4:    return "R5 expect";
            3'd5:    return "R7 tx done";
            default: return "R11 bad opcode";
        endcase
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // reset state: no response, no pulse, every object invalid
        check("R3 reset rsp_valid", 32'(rsp_valid), 0);
        check("R6 reset done_pulse", 32'(done_pulse), 0);
        for (int i = 0; i < NOBJ; i++) begin
            parity_q(2'(i), 1'b1);
            check("R10 reset query invalid", 32'(qry_done), 0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            issue(VECS[v].op, VECS[v].idx, VECS[v].arg);
            check("R3 rsp_valid", 32'(rsp_valid), 1);
            check(req_of(VECS[v].op), 32'(rsp_err), 32'(VECS[v].err));
            check("R3 token", 32'(rsp_token), 32'(VECS[v].tok));
            check("R6 done_pulse", 32'(done_pulse),
                  VECS[v].dn ? (32'd1 << VECS[v].idx) : 32'd0);
            parity_q(VECS[v].idx, 1'b0);
            check("R8 parity query", 32'(qry_done), 32'(VECS[v].qd));
        end

        // idle cycle gives no response
        @(negedge clk);
        check("R3 idle rsp_valid", 32'(rsp_valid), 0);

        // object 0 now in phase 0 (two phases done), object 1 in phase 1
        parity_q(2'd0, 1'b1);
        check("R8 parity odd done", 32'(qry_done), 1);
        token_q(3'b001, 2'd2);
        check("R9 token old phase", 32'(qry_done), 1);
        token_q(3'b000, 2'd1);
        check("R9 token current phase", 32'(qry_done), 0);
        token_q(3'b010, 2'd0);
        check("R9 token idx from token", 32'(qry_done), 1);
        token_q(3'b011, 2'd0);
        check("R9 token obj1 current", 32'(qry_done), 0);

        // largest count: setup, partial arrive leaving one, final arrive closes
        issue(3'd0, 2'd2, 20'hFFFFF);
        check("R2 max count setup err", 32'(rsp_err), 0);
        issue(3'd3, 2'd2, 20'hFFFFE);
        check("R4 large partial err", 32'(rsp_err), 0);
        check("R4 large partial no done", 32'(done_pulse), 0);
        issue(3'd2, 2'd2, 20'd0);
        check("R6 max count close", 32'(done_pulse), 32'h4);

        // transaction overflow rejected without consuming an arrival
        issue(3'd0, 2'd3, 20'd2);
        issue(3'd4, 2'd3, 20'hFFFFF);
        check("R5 expect max err", 32'(rsp_err), 0);
        issue(3'd4, 2'd3, 20'd1);
        check("R5 overflow err", 32'(rsp_err), 1);
        issue(3'd5, 2'd3, 20'hFFFFF);
        check("R5 tx drained no close", 32'(done_pulse), 0);
        check("R7 exact drain err", 32'(rsp_err), 0);
        issue(3'd2, 2'd3, 20'd0);
        check("R5 last arrival closes", 32'(done_pulse), 32'h8);
        parity_q(2'd3, 1'b0);
        check("R8 obj3 phase0 done", 32'(qry_done), 1);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule